// File: doc/BRIEF.md
# HDLC Receive Address Filter

This block sits between an HDLC deframer and a receive FIFO. Each byte arrives with a first-byte marker. A separate end cycle reports whether the CRC was good and whether the frame was aborted. Per frame, the block picks one of three receive modes and decides whether to keep the frame:

- **Transparent-all** keeps every frame.
- **Transparent-high** compares only the leading address byte.
- **Non-auto** checks a one-byte or two-byte address and stores only what follows it.

For every kept frame the block writes the chosen bytes to the FIFO, followed by one status byte. Kept frames with a bad CRC or an abort are written too, and their status byte marks the problem. The block also latches selected header bytes into readable registers.

The decision is made while the frame streams through, so nothing is buffered. The frame's address bytes are compared in the cycle they arrive. Later bytes are passed on once the frame has been accepted. A pulse marks every completed block of `POOL_BYTES` FIFO writes. A second pulse marks the end of each stored message.

Top module: `hdlc_rx_addr_filter`

## Requirements
- R1: The mode select `op_mode` is decoded at the first byte of a frame and held for that frame. 3'b100 is transparent-all, 3'b101 is transparent-high, 3'b010 and 3'b011 are non-auto. In transparent-all every frame is accepted and every byte is written to the FIFO.
- R2: In transparent-all, byte 0 of the frame is latched into `hdr_addr` and byte 1 into `hdr_ctrl`.
- R3: In transparent-high, byte 0 is compared against `hi_cmp_a`, `hi_cmp_b` and the fixed group values 0xFC and 0xFE. On a hit, the frame is stored from byte 1 onward, and byte 0 is never written.
- R4: In transparent-high on an accepted frame, byte 1 is latched into `hdr_addr` and byte 2 into `hdr_ctrl`.
- R5: In non-auto mode with `wide_addr`=0, byte 0 must equal `hi_cmp_a` or `hi_cmp_b` (no group values apply). The frame is stored from byte 1, byte 1 is latched into `hdr_ctrl`, and `hdr_addr` is left unchanged.
- R6: In non-auto mode with `wide_addr`=1, byte 0 must equal `hi_cmp_a` or `hi_cmp_b`, and byte 1 must equal `lo_cmp_a` or `lo_cmp_b`. Both must match. The frame is stored from byte 2, and byte 2 is latched into `hdr_ctrl`.
- R7: A frame is dropped if it fails its address check, if it arrives under codes 3'b000, 3'b001, 3'b110 or 3'b111, or if it ends before its address is complete. A dropped frame produces no FIFO write and no pulse, and `hdr_addr`, `hdr_ctrl` and `rx_status` keep their values.
- R8: Every accepted frame gets one status byte written after its data, whatever its CRC and abort flags. Bit 7 is crc_ok AND NOT aborted, bit 5 is crc_ok, bit 4 is aborted, and bits 6, 3, 2, 1 and 0 are zero. The same value is latched into `rx_status`.
- R9: `msg_end` is high for exactly one cycle, in the cycle after the status byte's write strobe.
- R10: `pool_full` is high together with `fifo_we` on every `POOL_BYTES`-th FIFO write counted since reset, with status bytes included and counting across frame boundaries. It is low otherwise.
- R11: A byte sampled on a clock edge appears on `fifo_wdata`/`fifo_we` right after that edge. The status byte appears right after the edge that samples `in_end`.
- R12: While `rst_n` is low, `fifo_we`, `pool_full`, `msg_end`, `hdr_addr`, `hdr_ctrl` and `rx_status` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_mode | input | 3 | Receive mode select, sampled at first byte |
| wide_addr | input | 1 | Non-auto address size: 0 one byte, 1 two bytes |
| hi_cmp_a | input | 8 | First high-byte compare value |
| hi_cmp_b | input | 8 | Second high-byte compare value |
| lo_cmp_a | input | 8 | First low-byte compare value |
| lo_cmp_b | input | 8 | Second low-byte compare value |
| in_valid | input | 1 | Byte present on in_data |
| in_first | input | 1 | Byte is the first after the opening flag |
| in_data | input | 8 | Received byte |
| in_end | input | 1 | Frame end cycle (no byte in this cycle) |
| in_crc_ok | input | 1 | CRC good, valid with in_end |
| in_abort | input | 1 | Frame aborted, valid with in_end |
| fifo_we | output | 1 | FIFO write strobe |
| fifo_wdata | output | 8 | FIFO write data |
| pool_full | output | 1 | Pulse on each completed block of POOL_BYTES writes |
| msg_end | output | 1 | Pulse after an accepted frame's status byte |
| hdr_addr | output | 8 | Latched address byte |
| hdr_ctrl | output | 8 | Latched control byte |
| rx_status | output | 8 | Latched status byte |

## Verification
The bench builds the block with `POOL_BYTES` set to 8 instead of 32. The short frames of the test then cross several pool boundaries, so the block-count pulse is checked both at boundaries inside a frame and at boundaries that fall on status bytes. The index width stays at its default of 2, so byte index 3 is the saturated value. Every header latch position (bytes 0 to 2) and the end of the two-byte address check therefore lie inside frames of at most four bytes.

// File: rtl/haf_pkg.sv
package haf_pkg;

  typedef enum logic [1:0] {
    HM_DROP  = 2'd0,
    HM_TR0   = 2'd1,
    HM_TR1   = 2'd2,
    HM_NAUTO = 2'd3
  } haf_mode_e;

  localparam logic [7:0] GROUP_A = 8'hFC;
  localparam logic [7:0] GROUP_B = 8'hFE;

  // Decode the three-bit select: {m1, m0, adm}
  function automatic haf_mode_e mode_of(input logic [2:0] sel);
    haf_mode_e m;
    if (sel[2:1] == 2'b01)   m = HM_NAUTO;
    else if (sel == 3'b100)  m = HM_TR0;
    else if (sel == 3'b101)  m = HM_TR1;
    else                     m = HM_DROP;
    return m;
  endfunction

  // Number of leading bytes consumed by the address check
  function automatic logic [1:0] hdr_len(input haf_mode_e m, input logic wide);
    logic [1:0] n;
    case (m)
      HM_TR1:   n = 2'd1;
      HM_NAUTO: n = wide ? 2'd2 : 2'd1;
      default:  n = 2'd0;
    endcase
    return n;
  endfunction

  // Trailing status byte
  function automatic logic [7:0] status_of(input logic crc_ok, input logic aborted);
    return {crc_ok & ~aborted, 1'b0, crc_ok, aborted, 4'h0};
  endfunction

endpackage

// File: rtl/haf_match.sv
module haf_match import haf_pkg::*; #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] byte_in,
  input  logic [DW-1:0] hi_a,
  input  logic [DW-1:0] hi_b,
  input  logic [DW-1:0] lo_a,
  input  logic [DW-1:0] lo_b,
  output logic          hi_hit,
  output logic          grp_hit,
  output logic          lo_hit
);

  always_comb begin
    hi_hit  = (byte_in == hi_a) || (byte_in == hi_b);
    grp_hit = (byte_in == DW'(GROUP_A)) || (byte_in == DW'(GROUP_B));
    lo_hit  = (byte_in == lo_a) || (byte_in == lo_b);
  end

endmodule

// File: rtl/haf_frame.sv
module haf_frame import haf_pkg::*; #(
  parameter int IDXW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      op_mode,
  input  logic            wide_addr,
  input  logic            in_valid,
  input  logic            in_first,
  input  logic            in_end,
  output haf_mode_e       mode_now,
  output logic            wide_now,
  output logic [IDXW-1:0] idx_now,
  output logic            byte_live,
  output logic            frame_open
);

  logic            live_q;
  logic            wide_q;
  logic [IDXW-1:0] idx_q;
  haf_mode_e       mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_q <= 1'b0;
      wide_q <= 1'b0;
      idx_q  <= '0;
      mode_q <= HM_DROP;
    end else if (in_valid && in_first) begin
      live_q <= 1'b1;
      wide_q <= wide_addr;
      mode_q <= mode_of(op_mode);
      idx_q  <= IDXW'(1);
    end else if (in_end) begin
      live_q <= 1'b0;
    end else if (in_valid && live_q && (idx_q != '1)) begin
      idx_q <= idx_q + IDXW'(1);
    end
  end

  always_comb begin
    mode_now   = in_first ? mode_of(op_mode) : mode_q;
    wide_now   = in_first ? wide_addr : wide_q;
    idx_now    = in_first ? '0 : idx_q;
    byte_live  = in_valid && (in_first || live_q);
    frame_open = live_q;
  end

endmodule

// File: rtl/haf_pool.sv
module haf_pool #(
  parameter int POOL_BYTES = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  output logic hit
);

  localparam int CW = (POOL_BYTES > 2) ? $clog2(POOL_BYTES) : 1;

  logic [CW-1:0] cnt_q;

  assign hit = wr && (cnt_q == CW'(POOL_BYTES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt_q <= '0;
    else if (wr)  cnt_q <= hit ? '0 : cnt_q + CW'(1);
  end

endmodule

// File: rtl/hdlc_rx_addr_filter.sv
module hdlc_rx_addr_filter import haf_pkg::*; #(
  parameter int POOL_BYTES = 32,
  parameter int DW         = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    op_mode,
  input  logic          wide_addr,
  input  logic [DW-1:0] hi_cmp_a,
  input  logic [DW-1:0] hi_cmp_b,
  input  logic [DW-1:0] lo_cmp_a,
  input  logic [DW-1:0] lo_cmp_b,
  input  logic          in_valid,
  input  logic          in_first,
  input  logic [DW-1:0] in_data,
  input  logic          in_end,
  input  logic          in_crc_ok,
  input  logic          in_abort,
  output logic          fifo_we,
  output logic [DW-1:0] fifo_wdata,
  output logic          pool_full,
  output logic          msg_end,
  output logic [DW-1:0] hdr_addr,
  output logic [DW-1:0] hdr_ctrl,
  output logic [DW-1:0] rx_status
);

  localparam int IDXW = 2;

  haf_mode_e       mode_now;
  logic            wide_now;
  logic [IDXW-1:0] idx_now;
  logic            byte_live;
  logic            frame_open;

  haf_frame #(.IDXW(IDXW)) u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_mode    (op_mode),
    .wide_addr  (wide_addr),
    .in_valid   (in_valid),
    .in_first   (in_first),
    .in_end     (in_end),
    .mode_now   (mode_now),
    .wide_now   (wide_now),
    .idx_now    (idx_now),
    .byte_live  (byte_live),
    .frame_open (frame_open)
  );

  logic hi_hit, grp_hit, lo_hit;

  haf_match #(.DW(DW)) u_match (
    .byte_in (in_data),
    .hi_a    (hi_cmp_a),
    .hi_b    (hi_cmp_b),
    .lo_a    (lo_cmp_a),
    .lo_b    (lo_cmp_b),
    .hi_hit  (hi_hit),
    .grp_hit (grp_hit),
    .lo_hit  (lo_hit)
  );

  // Frame decision state
  logic acc_q, pass_q;
  logic acc_d, pass_d, acc_prev;
  logic [IDXW-1:0] hlen;

  // Named internal events
  logic keep_now;   // current byte goes to the FIFO
  logic end_ev;     // status byte goes to the FIFO
  logic addr_ld, ctrl_ld;
  logic wr_now, pool_hit;
  logic [DW-1:0] stat_now;
  logic stat_wr_q;

  always_comb begin
    hlen     = IDXW'(hdr_len(mode_now, wide_now));
    acc_prev = in_first ? 1'b0 : acc_q;
    keep_now = byte_live &&
               ((mode_now == HM_TR0) ||
                ((mode_now != HM_DROP) && acc_prev && (idx_now >= hlen)));
    end_ev   = in_end && frame_open && acc_q;
    wr_now   = keep_now || end_ev;
    stat_now = DW'(status_of(in_crc_ok, in_abort));

    addr_ld  = keep_now &&
               (((mode_now == HM_TR0) && (idx_now == IDXW'(0))) ||
                ((mode_now == HM_TR1) && (idx_now == IDXW'(1))));
    ctrl_ld  = keep_now &&
               (((mode_now == HM_TR0)   && (idx_now == IDXW'(1))) ||
                ((mode_now == HM_TR1)   && (idx_now == IDXW'(2))) ||
                ((mode_now == HM_NAUTO) && (idx_now == hlen)));
  end

  always_comb begin
    acc_d  = acc_prev;
    pass_d = in_first ? 1'b0 : pass_q;
    if (byte_live) begin
      case (mode_now)
        HM_TR0: begin
          if (idx_now == IDXW'(0)) acc_d = 1'b1;
        end
        HM_TR1: begin
          if (idx_now == IDXW'(0)) acc_d = hi_hit || grp_hit;
        end
        HM_NAUTO: begin
          if (idx_now == IDXW'(0)) begin
            if (wide_now) pass_d = hi_hit;
            else          acc_d  = hi_hit;
          end else if ((idx_now == IDXW'(1)) && wide_now) begin
            acc_d = pass_q && lo_hit;
          end
        end
        default: acc_d = 1'b0;
      endcase
    end
    if (in_end) begin
      acc_d  = 1'b0;
      pass_d = 1'b0;
    end
  end

  haf_pool #(.POOL_BYTES(POOL_BYTES)) u_pool (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (wr_now),
    .hit   (pool_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q      <= 1'b0;
      pass_q     <= 1'b0;
      fifo_we    <= 1'b0;
      fifo_wdata <= '0;
      pool_full  <= 1'b0;
      stat_wr_q  <= 1'b0;
      msg_end    <= 1'b0;
      hdr_addr   <= '0;
      hdr_ctrl   <= '0;
      rx_status  <= '0;
    end else begin
      acc_q      <= acc_d;
      pass_q     <= pass_d;
      fifo_we    <= wr_now;
      fifo_wdata <= end_ev ? stat_now : in_data;
      pool_full  <= pool_hit;
      stat_wr_q  <= end_ev;
      msg_end    <= stat_wr_q;
      if (addr_ld) hdr_addr  <= in_data;
      if (ctrl_ld) hdr_ctrl  <= in_data;
      if (end_ev)  rx_status <= stat_now;
    end
  end

endmodule

// File: rtl/haf_chk.sv
module haf_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_end,
  input logic          fifo_we,
  input logic [DW-1:0] fifo_wdata,
  input logic          pool_full,
  input logic          msg_end,
  input logic [DW-1:0] hdr_addr,
  input logic [DW-1:0] hdr_ctrl,
  input logic [DW-1:0] rx_status
);

  p_pool_with_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pool_full |-> fifo_we);

  p_msg_after_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
    msg_end |-> ($past(fifo_we) && ($past(fifo_wdata[3:0]) == 4'h0) && !$past(fifo_wdata[6])));

  p_msg_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    msg_end |=> !msg_end);

  p_status_valid_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    msg_end |-> ($past(fifo_wdata[7]) == ($past(fifo_wdata[5]) && !$past(fifo_wdata[4]))));

  p_msg_follows_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
    msg_end |-> $past(in_end, 2));

  p_write_has_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_we |-> ($past(in_valid) || $past(in_end)));

  p_addr_moves_on_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(hdr_addr) |-> fifo_we);

  p_ctrl_moves_on_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(hdr_ctrl) |-> fifo_we);

  p_status_reg_then_msg_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_status) |=> msg_end);

endmodule

bind hdlc_rx_addr_filter haf_chk #(.DW(DW)) u_haf_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_end     (in_end),
  .fifo_we    (fifo_we),
  .fifo_wdata (fifo_wdata),
  .pool_full  (pool_full),
  .msg_end    (msg_end),
  .hdr_addr   (hdr_addr),
  .hdr_ctrl   (hdr_ctrl),
  .rx_status  (rx_status)
);

// File: tb/tb_hdlc_rx_addr_filter.sv
`timescale 1ns/1ps
module tb_hdlc_rx_addr_filter;

  localparam int POOL = 8;
  localparam logic [7:0] HA = 8'h40, HB = 8'h42, LA = 8'h10, LB = 8'h12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] op_mode = 3'b000;
  logic wide_addr = 1'b0;
  logic [7:0] hi_cmp_a = HA, hi_cmp_b = HB, lo_cmp_a = LA, lo_cmp_b = LB;
  logic in_valid = 1'b0, in_first = 1'b0, in_end = 1'b0, in_crc_ok = 1'b0, in_abort = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic fifo_we, pool_full, msg_end;
  logic [7:0] fifo_wdata, hdr_addr, hdr_ctrl, rx_status;

  always #2 clk = ~clk;

  hdlc_rx_addr_filter #(.POOL_BYTES(POOL)) dut (
    .clk(clk), .rst_n(rst_n), .op_mode(op_mode), .wide_addr(wide_addr),
    .hi_cmp_a(hi_cmp_a), .hi_cmp_b(hi_cmp_b), .lo_cmp_a(lo_cmp_a), .lo_cmp_b(lo_cmp_b),
    .in_valid(in_valid), .in_first(in_first), .in_data(in_data), .in_end(in_end),
    .in_crc_ok(in_crc_ok), .in_abort(in_abort),
    .fifo_we(fifo_we), .fifo_wdata(fifo_wdata), .pool_full(pool_full), .msg_end(msg_end),
    .hdr_addr(hdr_addr), .hdr_ctrl(hdr_ctrl), .rx_status(rx_status)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;
  string cur_tag = "R12";
  logic [8:0] sb_q[$];
  int wcnt = 0;
  bit last_status = 0;
  logic [7:0] exp_addr = 8'h00, exp_ctrl = 8'h00, exp_stat = 8'h00;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] want_status(input logic crc, input logic abt);
    logic [7:0] s;
    s = 8'h00;
    s[7] = crc && !abt;
    s[5] = crc;
    s[4] = abt;
    return s;
  endfunction

  // Monitor: pops the scoreboard as writes come out
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (msg_end || last_status) begin
        total++;
        if (msg_end !== last_status) begin
          bad++;
          $display("FAIL R9 (%s): msg_end actual=%b expected=%b", cur_tag, msg_end, last_status);
        end
      end
      last_status = 0;
      if (fifo_we) begin
        total++;
        if (sb_q.size() == 0) begin
          bad++;
          $display("FAIL R7 (%s): unexpected write actual=%h expected=none", cur_tag, fifo_wdata);
        end else begin
          logic [8:0] it;
          it = sb_q.pop_front();
          if (fifo_wdata !== it[7:0]) begin
            bad++;
            $display("FAIL %s: fifo data actual=%h expected=%h", cur_tag, fifo_wdata, it[7:0]);
          end
          last_status = it[8];
        end
        total++;
        if (pool_full !== ((wcnt % POOL) == POOL - 1)) begin
          bad++;
          $display("FAIL R10: pool_full actual=%b expected=%b at write %0d",
                   pool_full, ((wcnt % POOL) == POOL - 1), wcnt);
        end
        wcnt++;
      end else if (pool_full) begin
        total++; bad++;
        $display("FAIL R10: pool_full actual=1 expected=0 without write");
      end
    end
  end

  task automatic send(input string tag, input logic [2:0] md, input logic wide, input int n,
                      input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                      input logic [7:0] b3, input logic crc, input logic abt);
    logic [7:0] b[4];
    int h;
    logic acc;
    b[0] = b0; b[1] = b1; b[2] = b2; b[3] = b3;
    acc = 0; h = 0;
    if (md == 3'b100) begin
      acc = (n >= 1); h = 0;
    end else if (md == 3'b101) begin
      h = 1;
      acc = (n >= 1) && (b0 == HA || b0 == HB || b0 == 8'hFC || b0 == 8'hFE);
    end else if (md[2:1] == 2'b01) begin
      h = wide ? 2 : 1;
      acc = (n >= h) && (b0 == HA || b0 == HB) && (!wide || b1 == LA || b1 == LB);
    end
    cur_tag = tag;
    if (acc) begin
      for (int i = h; i < n; i++) sb_q.push_back({1'b0, b[i]});
      sb_q.push_back({1'b1, want_status(crc, abt)});
      exp_stat = want_status(crc, abt);
      if (md == 3'b100) begin
        if (n >= 1) exp_addr = b[0];
        if (n >= 2) exp_ctrl = b[1];
      end else if (md == 3'b101) begin
        if (n >= 2) exp_addr = b[1];
        if (n >= 3) exp_ctrl = b[2];
      end else begin
        if (n > h) exp_ctrl = b[h];
      end
    end
    op_mode = md;
    wide_addr = wide;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1; in_first = (i == 0); in_data = b[i];
    end
    @(negedge clk);
    in_valid = 0; in_first = 0; in_end = 1; in_crc_ok = crc; in_abort = abt;
    @(negedge clk);
    in_end = 0;
    repeat (3) @(negedge clk);
    chk({tag, " hdr_addr"}, hdr_addr, exp_addr);
    chk({tag, " hdr_ctrl"}, hdr_ctrl, exp_ctrl);
    chk({tag, " rx_status"}, rx_status, exp_stat);
    total++;
    if (sb_q.size() != 0) begin
      bad++;
      $display("FAIL %s: pending writes actual=%0d expected=0", tag, sb_q.size());
      sb_q.delete();
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 fifo_we", {7'b0, fifo_we}, 8'h00);
    chk("R12 pool_full", {7'b0, pool_full}, 8'h00);
    chk("R12 msg_end", {7'b0, msg_end}, 8'h00);
    chk("R12 hdr_addr", hdr_addr, 8'h00);
    chk("R12 hdr_ctrl", hdr_ctrl, 8'h00);
    chk("R12 rx_status", rx_status, 8'h00);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R11 cycle timing, transparent-all one byte frame
    cur_tag = "R11";
    op_mode = 3'b100;
    sb_q.push_back({1'b0, 8'h5A});
    sb_q.push_back({1'b1, 8'hA0});
    in_valid = 1; in_first = 1; in_data = 8'h5A;
    @(negedge clk);
    in_valid = 0; in_first = 0;
    chk("R11 byte strobe", {7'b0, fifo_we}, 8'h01);
    chk("R11 byte data", fifo_wdata, 8'h5A);
    in_end = 1; in_crc_ok = 1; in_abort = 0;
    @(negedge clk);
    in_end = 0;
    chk("R11 status strobe", {7'b0, fifo_we}, 8'h01);
    chk("R11 status data", fifo_wdata, 8'hA0);
    @(negedge clk);
    chk("R9 msg_end pulse", {7'b0, msg_end}, 8'h01);
    exp_addr = 8'h5A; exp_stat = 8'hA0;
    repeat (3) @(negedge clk);

    send("R1 tr0 store all",   3'b100, 0, 4, 8'h11, 8'h22, 8'h33, 8'h44, 1, 0);
    send("R2 tr0 latch",       3'b100, 0, 3, 8'h91, 8'h92, 8'h93, 8'h00, 1, 0);
    send("R3 tr1 hit hi_a",    3'b101, 0, 4, HA,    8'h55, 8'h66, 8'h77, 1, 0);
    send("R4 tr1 latch hi_b",  3'b101, 0, 3, HB,    8'h61, 8'h62, 8'h00, 1, 0);
    send("R3 tr1 group FE",    3'b101, 0, 3, 8'hFE, 8'h01, 8'h02, 8'h00, 1, 0);
    send("R3 tr1 group FC",    3'b101, 0, 4, 8'hFC, 8'h03, 8'h04, 8'h05, 1, 0);
    send("R7 tr1 miss",        3'b101, 0, 4, 8'h41, 8'hE1, 8'hE2, 8'hE3, 1, 0);
    send("R5 nauto narrow",    3'b010, 0, 4, HB,    8'h07, 8'h08, 8'h09, 1, 0);
    send("R5 nauto no group",  3'b011, 0, 3, 8'hFE, 8'hD1, 8'hD2, 8'h00, 1, 0);
    send("R6 nauto wide",      3'b010, 1, 4, HA,    LA,    8'h0A, 8'h0B, 1, 0);
    send("R6 nauto wide lo_b", 3'b011, 1, 3, HB,    LB,    8'h0C, 8'h00, 1, 0);
    send("R6 wide lo miss",    3'b010, 1, 4, HA,    8'h11, 8'hC1, 8'hC2, 1, 0);
    send("R6 wide hi miss",    3'b010, 1, 4, 8'h43, LA,    8'hC3, 8'hC4, 1, 0);
    send("R7 wide too short",  3'b010, 1, 1, HA,    8'h00, 8'h00, 8'h00, 1, 0);
    send("R7 mode 000",        3'b000, 0, 3, 8'hB1, 8'hB2, 8'hB3, 8'h00, 1, 0);
    send("R7 mode 111",        3'b111, 0, 3, HA,    8'hB4, 8'hB5, 8'h00, 1, 0);
    send("R8 bad crc",         3'b100, 0, 2, 8'h21, 8'h23, 8'h00, 8'h00, 0, 0);
    send("R8 abort",           3'b101, 0, 3, HA,    8'h24, 8'h25, 8'h00, 0, 1);
    send("R8 abort crc ok",    3'b010, 0, 2, HA,    8'h26, 8'h00, 8'h00, 1, 1);
    for (int k = 0; k < 5; k++)
      send("R10 pool run",     3'b100, 0, 4, 8'h30 + 8'(k), 8'h31, 8'h32, 8'h33, 1, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule